// File: doc/BRIEF.md
# Floating-Point Load/Store Decoder

This block takes one 32-bit instruction word and decides whether it is a floating-point memory access. If it is, the block works out the effective address, whether the access reads or writes memory, whether it moves a single (4-byte) or double (8-byte) value, and whether the base register must be updated with the new address. Two instruction layouts are recognised:

- a displacement form, selected by a primary opcode in a contiguous band;
- an indexed form, reached through primary opcode 31 and an extended opcode.

A store variant that writes the low word of a floating-point register as a raw integer is also recognised, with no format conversion.

The caller supplies the instruction together with the values of the two general registers it names. The decoded result goes into one output register stage with a valid/ready handshake. For every update form, the result includes a write-back of the address to the base register. Forms that are not valid, including an update whose base register is register 0, produce an illegal-instruction flag. In that case no control flag and no write-back are raised.

Top module: `fpls_decoder`

## Requirements
- R1: With the primary opcode in insn[31:26] in the range 48 to 55, the access is a displacement form. Opcode bit 2 selects a store (else a load), bit 1 selects double (else single), and bit 0 selects update.
- R2: With primary opcode 31 and the extended opcode xo = insn[10:1], the access is legal exactly when (xo & 0x31F) == 0x217, which gives the values 535, 567, … 759. In that case xo bit 7 selects a store, bit 6 selects double and bit 5 selects update.
- R3: The displacement-form address is the sign-extended insn[15:0] plus the base value gpr_a. When the base field ra = insn[20:16] is 0, the base contributes zero rather than gpr_a.
- R4: The indexed-form address is gpr_b plus gpr_a, where a base field ra of 0 contributes zero.
- R5: An update form with ra = 0 is illegal. A legal update raises wb_en, with wb_idx = ra and wb_data = the address. Without wb_en, wb_idx and wb_data are 0.
- R6: Opcode 31 with xo = 983 is the integer-word store. It gives a store of 4 bytes with is_intword set, no double, no update and no conversion request. Its address is computed as in R4.
- R7: Any other primary opcode, and opcode 31 with any other xo, is illegal. When illegal is set, all of the following are 0: is_store, is_double, is_update, is_intword, conv_req, wb_en, acc_bytes, ea and wb_data.
- R8: For a legal access, acc_bytes is 4 for single and 8 for double. conv_req is set only for a legal single access that is not the integer-word store.
- R9: frt carries insn[25:21], ra_idx carries insn[20:16] and rb_idx carries insn[15:11], for every accepted instruction.
- R10: in_ready = !out_valid || out_ready. An instruction accepted on an edge is presented on out_valid right after that edge. While out_valid is high and out_ready is low, every output holds.
- R11: After reset, out_valid is 0 and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction can be taken |
| insn | input | 32 | Instruction word |
| gpr_a | input | XLEN | Value of the register named by insn[20:16] |
| gpr_b | input | XLEN | Value of the register named by insn[15:11] |
| out_valid | output | 1 | Decoded result present |
| out_ready | input | 1 | Consumer takes the result |
| ea | output | XLEN | Effective address |
| is_store | output | 1 | Access writes memory |
| is_double | output | 1 | 8-byte access |
| is_update | output | 1 | Update form |
| is_intword | output | 1 | Integer-word store |
| conv_req | output | 1 | Single value needs widening or narrowing |
| acc_bytes | output | 4 | Access size in bytes |
| frt | output | 5 | Floating-point register index |
| ra_idx | output | 5 | Base register index |
| rb_idx | output | 5 | Index register field |
| illegal | output | 1 | Not a valid floating-point load/store |
| wb_en | output | 1 | Write the address back to the base register |
| wb_idx | output | 5 | Write-back register index |
| wb_data | output | XLEN | Write-back value |

## Verification
On every cycle, the assertions check the consistency rules between the outputs:

- an update result never names base register 0;
- a write-back always carries the presented address;
- an illegal result has every flag quiet;
- the integer-word store and conversion requests keep their fixed sizes;
- the output holds under back-pressure, one cycle after an accept.

Only the bench scenarios can show that each opcode maps to the right direction, size and update setting. The same holds for the arithmetic values of the addresses: negative displacements, a zero base and indexed sums. It also holds for exactly which opcode and extended-opcode values are rejected.

// File: rtl/fpls_pkg.sv
package fpls_pkg;
  localparam int OPC_W = 6;
  localparam int XO_W  = 10;
  localparam int REG_W = 5;
  localparam int DISP_W = 16;
  localparam int BYTES_W = 4;

  localparam logic [OPC_W-1:0] OPC_INDEXED = 6'd31;
  localparam logic [2:0]       DISP_BAND   = 3'b110;
  localparam logic [XO_W-1:0]  XO_MASK     = 10'h31F;
  localparam logic [XO_W-1:0]  XO_PATTERN  = 10'h217;
  localparam logic [XO_W-1:0]  XO_INTWORD  = 10'd983;

  typedef struct packed {
    logic hit;
    logic store;
    logic dbl;
    logic upd;
    logic intword;
  } form_t;

  typedef struct packed {
    logic               illegal;
    logic               store;
    logic               dbl;
    logic               upd;
    logic               intword;
    logic               conv;
    logic [BYTES_W-1:0] bytes;
    logic [REG_W-1:0]   frt;
    logic [REG_W-1:0]   ra;
    logic [REG_W-1:0]   rb;
    logic               wb_en;
    logic [REG_W-1:0]   wb_idx;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

  function automatic logic [OPC_W-1:0] f_opcd(input logic [31:0] w);
    return w[31:26];
  endfunction

  function automatic logic [REG_W-1:0] f_rt(input logic [31:0] w);
    return w[25:21];
  endfunction

  function automatic logic [REG_W-1:0] f_ra(input logic [31:0] w);
    return w[20:16];
  endfunction

  function automatic logic [REG_W-1:0] f_rb(input logic [31:0] w);
    return w[15:11];
  endfunction

  function automatic logic [XO_W-1:0] f_xo(input logic [31:0] w);
    return w[10:1];
  endfunction

  function automatic logic [DISP_W-1:0] f_disp(input logic [31:0] w);
    return w[15:0];
  endfunction

  function automatic logic [BYTES_W-1:0] f_bytes(input logic dbl);
    return dbl ? 4'd8 : 4'd4;
  endfunction
endpackage

// File: rtl/fpls_dform_dec.sv
module fpls_dform_dec
  import fpls_pkg::*;
(
  input  logic [OPC_W-1:0] opcd,
  output form_t            form
);
  always_comb begin
    form         = '0;
    form.hit     = (opcd[5:3] == DISP_BAND);
    form.store   = form.hit & opcd[2];
    form.dbl     = form.hit & opcd[1];
    form.upd     = form.hit & opcd[0];
    form.intword = 1'b0;
  end
endmodule

// File: rtl/fpls_xform_dec.sv
module fpls_xform_dec
  import fpls_pkg::*;
(
  input  logic [OPC_W-1:0] opcd,
  input  logic [XO_W-1:0]  xo,
  output form_t            form
);
  logic is31;
  logic iw_hit;
  logic fp_hit;

  assign is31   = (opcd == OPC_INDEXED);
  assign iw_hit = is31 && (xo == XO_INTWORD);
  assign fp_hit = is31 && ((xo & XO_MASK) == XO_PATTERN);

  always_comb begin
    form = '0;
    if (iw_hit) begin
      form.hit     = 1'b1;
      form.store   = 1'b1;
      form.intword = 1'b1;
    end else if (fp_hit) begin
      form.hit   = 1'b1;
      form.store = xo[7];
      form.dbl   = xo[6];
      form.upd   = xo[5];
    end
  end
endmodule

// File: rtl/fpls_ea_gen.sv
module fpls_ea_gen
  import fpls_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              indexed,
  input  logic              ra_zero,
  input  logic [XLEN-1:0]   gpr_a,
  input  logic [XLEN-1:0]   gpr_b,
  input  logic [DISP_W-1:0] disp,
  output logic [XLEN-1:0]   ea
);
  logic [XLEN-1:0] disp_ext;
  logic [XLEN-1:0] base;
  logic [XLEN-1:0] offset;

  generate
    if (XLEN > DISP_W) begin : g_sext
      assign disp_ext = {{(XLEN-DISP_W){disp[DISP_W-1]}}, disp};
    end else begin : g_trunc
      assign disp_ext = disp[XLEN-1:0];
    end
  endgenerate

  assign base   = ra_zero ? '0 : gpr_a;
  assign offset = indexed ? gpr_b : disp_ext;
  assign ea     = base + offset;
endmodule

// File: rtl/fpls_out_reg.sv
module fpls_out_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] din,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] dout
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dout      <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) dout <= din;
    end
  end
endmodule

// File: rtl/fpls_decoder.sv
module fpls_decoder
  import fpls_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [31:0]      insn,
  input  logic [XLEN-1:0]  gpr_a,
  input  logic [XLEN-1:0]  gpr_b,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [XLEN-1:0]  ea,
  output logic             is_store,
  output logic             is_double,
  output logic             is_update,
  output logic             is_intword,
  output logic             conv_req,
  output logic [3:0]       acc_bytes,
  output logic [4:0]       frt,
  output logic [4:0]       ra_idx,
  output logic [4:0]       rb_idx,
  output logic             illegal,
  output logic             wb_en,
  output logic [4:0]       wb_idx,
  output logic [XLEN-1:0]  wb_data
);
  localparam int PAY_W = CTL_W + 2 * XLEN;

  form_t            dform;
  form_t            xform;
  form_t            sel;
  logic [REG_W-1:0] ra_f;
  logic             ra_zero;
  logic [XLEN-1:0]  ea_raw;
  logic             bad_update;
  logic             dec_legal;
  logic             accept;
  ctl_t             ctl_d;
  ctl_t             ctl_q;
  logic [XLEN-1:0]  ea_d;
  logic [XLEN-1:0]  wbd_d;
  logic [PAY_W-1:0] pay_q;
  logic             unused_rc;

  assign unused_rc = insn[0];
  assign ra_f      = f_ra(insn);
  assign ra_zero   = (ra_f == '0);

  fpls_dform_dec u_dform (
    .opcd (f_opcd(insn)),
    .form (dform)
  );

  fpls_xform_dec u_xform (
    .opcd (f_opcd(insn)),
    .xo   (f_xo(insn)),
    .form (xform)
  );

  assign sel = xform.hit ? xform : dform;

  fpls_ea_gen #(.XLEN(XLEN)) u_ea (
    .indexed (xform.hit),
    .ra_zero (ra_zero),
    .gpr_a   (gpr_a),
    .gpr_b   (gpr_b),
    .disp    (f_disp(insn)),
    .ea      (ea_raw)
  );

  assign bad_update = sel.upd && ra_zero;
  assign dec_legal  = sel.hit && !bad_update;

  always_comb begin
    ctl_d         = '0;
    ctl_d.illegal = !dec_legal;
    ctl_d.store   = dec_legal & sel.store;
    ctl_d.dbl     = dec_legal & sel.dbl;
    ctl_d.upd     = dec_legal & sel.upd;
    ctl_d.intword = dec_legal & sel.intword;
    ctl_d.conv    = dec_legal & !sel.dbl & !sel.intword;
    ctl_d.bytes   = dec_legal ? f_bytes(sel.dbl) : '0;
    ctl_d.frt     = f_rt(insn);
    ctl_d.ra      = ra_f;
    ctl_d.rb      = f_rb(insn);
    ctl_d.wb_en   = dec_legal & sel.upd;
    ctl_d.wb_idx  = ctl_d.wb_en ? ra_f : '0;
  end

  assign ea_d  = dec_legal ? ea_raw : '0;
  assign wbd_d = ctl_d.wb_en ? ea_raw : '0;

  fpls_out_reg #(.W(PAY_W)) u_oreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .din       ({ctl_d, ea_d, wbd_d}),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .dout      (pay_q)
  );

  assign accept  = in_valid && in_ready;
  assign ctl_q   = pay_q[PAY_W-1 -: CTL_W];
  assign ea      = pay_q[2*XLEN-1 -: XLEN];
  assign wb_data = pay_q[XLEN-1:0];

  assign illegal    = ctl_q.illegal;
  assign is_store   = ctl_q.store;
  assign is_double  = ctl_q.dbl;
  assign is_update  = ctl_q.upd;
  assign is_intword = ctl_q.intword;
  assign conv_req   = ctl_q.conv;
  assign acc_bytes  = ctl_q.bytes;
  assign frt        = ctl_q.frt;
  assign ra_idx     = ctl_q.ra;
  assign rb_idx     = ctl_q.rb;
  assign wb_en      = ctl_q.wb_en;
  assign wb_idx     = ctl_q.wb_idx;
endmodule

// File: rtl/fpls_checker.sv
module fpls_checker #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            accept,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [XLEN-1:0] ea,
  input logic            is_store,
  input logic            is_double,
  input logic            is_update,
  input logic            is_intword,
  input logic            conv_req,
  input logic [3:0]      acc_bytes,
  input logic [4:0]      ra_idx,
  input logic            illegal,
  input logic            wb_en,
  input logic [4:0]      wb_idx,
  input logic [XLEN-1:0] wb_data
);
  p_wb_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && wb_en |-> is_update && !illegal && ra_idx != 5'd0 &&
                           wb_idx == ra_idx && wb_data == ea);

  p_upd_base_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && is_update |-> ra_idx != 5'd0 && wb_en);

  p_illegal_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && illegal |-> !is_store && !is_double && !is_update &&
                             !is_intword && !conv_req && !wb_en &&
                             acc_bytes == 4'd0 && ea == '0);

  p_intword_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && is_intword |-> is_store && !is_double && !is_update &&
                                !conv_req && acc_bytes == 4'd4);

  p_conv_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && conv_req |-> !is_double && !illegal && acc_bytes == 4'd4);

  p_size_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !illegal |-> $countones({acc_bytes == 4'd4, acc_bytes == 4'd8}) == 1);

  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  p_stall_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(ea) && $stable(wb_data) &&
                                $stable(is_store) && $stable(illegal) &&
                                $stable(acc_bytes));
endmodule

bind fpls_decoder fpls_checker #(.XLEN(XLEN)) u_fpls_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .accept     (accept),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .ea         (ea),
  .is_store   (is_store),
  .is_double  (is_double),
  .is_update  (is_update),
  .is_intword (is_intword),
  .conv_req   (conv_req),
  .acc_bytes  (acc_bytes),
  .ra_idx     (ra_idx),
  .illegal    (illegal),
  .wb_en      (wb_en),
  .wb_idx     (wb_idx),
  .wb_data    (wb_data)
);

// File: tb/tb_fpls_decoder.sv
`timescale 1ns/1ps
module tb_fpls_decoder;
  localparam int XL = 32;
  localparam int VW = 95;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [31:0]   insn = '0;
  logic [XL-1:0] gpr_a = '0;
  logic [XL-1:0] gpr_b = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [XL-1:0] ea, wb_data;
  logic          is_store, is_double, is_update, is_intword, conv_req, illegal, wb_en;
  logic [3:0]    acc_bytes;
  logic [4:0]    frt, ra_idx, rb_idx, wb_idx;

  int checks = 0;
  int failures = 0;
  bit bp = 1'b0;
  bit done = 1'b0;
  logic [VW-1:0] exp_q[$];
  string         tag_q[$];

  always #4 clk = ~clk;

  fpls_decoder #(.XLEN(XL)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .insn(insn), .gpr_a(gpr_a), .gpr_b(gpr_b), .out_valid(out_valid),
    .out_ready(out_ready), .ea(ea), .is_store(is_store), .is_double(is_double),
    .is_update(is_update), .is_intword(is_intword), .conv_req(conv_req),
    .acc_bytes(acc_bytes), .frt(frt), .ra_idx(ra_idx), .rb_idx(rb_idx),
    .illegal(illegal), .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data)
  );

  function automatic logic [VW-1:0] actual();
    return {illegal, is_store, is_double, is_update, is_intword, conv_req,
            acc_bytes, frt, ra_idx, rb_idx, wb_en, wb_idx, wb_data, ea};
  endfunction

  function automatic logic [VW-1:0] model(logic [31:0] i, logic [31:0] a, logic [31:0] b);
    int op, xi, k;
    logic ok, st, dp, up, iw, cv;
    logic [4:0] rt, ra, rb;
    logic [31:0] e, base;
    logic [3:0] nb;
    op = int'(i[31:26]); xi = int'(i[10:1]);
    rt = i[25:21]; ra = i[20:16]; rb = i[15:11];
    base = (ra == 5'd0) ? 32'd0 : a;
    ok = 0; st = 0; dp = 0; up = 0; iw = 0; k = 0; e = 0;
    if (op >= 48 && op <= 55) begin
      ok = 1; k = op - 48;
      e = base + {{16{i[15]}}, i[15:0]};
    end else if (op == 31) begin
      e = base + b;
      if (xi == 983) begin ok = 1; iw = 1; end
      else if (xi >= 535 && xi <= 759 && ((xi - 535) % 32) == 0) begin
        ok = 1; k = (xi - 535) / 32;
      end
    end
    if (ok && !iw) begin st = (k >= 4); dp = ((k % 4) >= 2); up = ((k % 2) == 1); end
    if (iw) st = 1;
    if (up && ra == 5'd0) ok = 0;
    if (!ok) return {1'b1, 5'b0, 4'd0, rt, ra, rb, 1'b0, 5'd0, 64'd0};
    cv = !dp && !iw;
    nb = dp ? 4'd8 : 4'd4;
    return {1'b0, st, dp, up, iw, cv, nb, rt, ra, rb, up, up ? ra : 5'd0,
            up ? e : 32'd0, e};
  endfunction

  function automatic logic [31:0] mk_d(int op, logic [4:0] rt, logic [4:0] ra, logic [15:0] d);
    return {op[5:0], rt, ra, d};
  endfunction

  function automatic logic [31:0] mk_x(logic [4:0] rt, logic [4:0] ra, logic [4:0] rb, int xo);
    return {6'd31, rt, ra, rb, xo[9:0], 1'b0};
  endfunction

  task automatic check(bit ok, string req, logic [VW-1:0] act, logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(logic [31:0] i, logic [31:0] a, logic [31:0] b, string tag);
    exp_q.push_back(model(i, a, b));
    tag_q.push_back(tag);
    @(negedge clk);
    insn = i; gpr_a = a; gpr_b = b; in_valid = 1'b1;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // back-pressure pattern
  initial begin
    logic [7:0] lf;
    lf = 8'hA5;
    forever begin
      @(negedge clk);
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      out_ready = bp ? lf[0] : 1'b1;
    end
  end

  // monitor / scoreboard
  initial begin
    bit stalled;
    logic [VW-1:0] held, e, a;
    string t;
    stalled = 0; held = '0;
    forever begin
      @(negedge clk); #1;
      if (rst_n) begin
        a = actual();
        if (stalled)
          check(out_valid && a == held, "R10 hold", a, held);
        if (out_valid && !out_ready)
          check(!in_ready, "R10 ready", {94'd0, in_ready}, '0);
        stalled = out_valid && !out_ready;
        held = a;
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) check(0, "R10 unexpected", a, '0);
          else begin
            e = exp_q.pop_front(); t = tag_q.pop_front();
            check(a == e, t, a, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid && in_ready && actual() == '0, "R11 reset", actual(), '0);
    @(negedge clk); rst_n = 1'b1;

    send(mk_d(50, 5'd2, 5'd3, 16'h0010), 32'h1000, 32'h0, "R10 latency/R1/R3");
    #2;
    check(out_valid, "R10 latency", {94'd0, out_valid}, {94'd0, 1'b1});

    for (int op = 48; op <= 55; op++)
      send(mk_d(op, 5'(op), 5'd3, (op % 2) ? 16'hFFF0 : 16'h0020),
           32'h0000_1000, 32'h5555, "R1/R3/R5/R8");
    send(mk_d(48, 5'd1, 5'd0, 16'h8000), 32'hDEAD_BEEF, 32'h0, "R3 base0 negdisp");
    send(mk_d(54, 5'd9, 5'd0, 16'h7FFF), 32'h1234, 32'h0, "R3 base0 posdisp");

    for (int k = 0; k < 8; k++)
      send(mk_x(5'(k + 10), 5'd4, 5'(k + 20), 535 + 32 * k),
           32'h2000_0000, 32'h44 + k, "R2/R4/R5/R8/R9");
    send(mk_x(5'd7, 5'd0, 5'd5, 599), 32'hFFFF_FFFF, 32'h1234, "R4 base0");

    send(mk_d(49, 5'd1, 5'd0, 16'h0008), 32'h100, 32'h0, "R5 dupd ra0");
    send(mk_d(55, 5'd1, 5'd0, 16'h0008), 32'h100, 32'h0, "R5 dupd ra0 st");
    send(mk_x(5'd3, 5'd0, 5'd2, 759), 32'h100, 32'h80, "R5 xupd ra0");

    send(mk_x(5'd12, 5'd6, 5'd7, 983), 32'h4000, 32'h0C, "R6 intword");
    send(mk_x(5'd12, 5'd0, 5'd7, 983), 32'h4000, 32'h0C, "R6 intword base0");

    send(mk_d(47, 5'd1, 5'd2, 16'h0004), 32'h10, 32'h0, "R7 op47");
    send(mk_d(56, 5'd1, 5'd2, 16'h0004), 32'h10, 32'h0, "R7 op56");
    send(mk_d(0, 5'd1, 5'd2, 16'h0004), 32'h10, 32'h0, "R7 op0");
    send(mk_x(5'd1, 5'd2, 5'd3, 266), 32'h10, 32'h20, "R7 xo266");
    send(mk_x(5'd1, 5'd2, 5'd3, 791), 32'h10, 32'h20, "R7 xo791");
    send(mk_x(5'd1, 5'd2, 5'd3, 984), 32'h10, 32'h20, "R7 xo984");

    bp = 1'b1;
    for (int n = 0; n < 32; n++) begin
      if (n % 3 == 0)
        send(mk_d(48 + (n % 8), 5'(n), 5'(n % 4), 16'(n * 37)), 32'h100 * n, 32'h0,
             "R10 bp/R1/R3/R5");
      else
        send(mk_x(5'(n), 5'(n % 5), 5'(31 - n), (n % 7 == 0) ? 983 : 535 + 32 * (n % 8)),
             32'h10 * n, 32'h3 * n, "R10 bp/R2/R4/R6/R9");
    end
    bp = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule